// File: doc/BRIEF.md
# GPIO Interrupt Event Unit

This block watches a bank of 32 general-purpose input pins and turns selected pin conditions into interrupt events. The pins are first brought into the clock domain by a two-flop stage. Each pin can watch for any combination of four conditions: a low level, a high level, a rising edge and a falling edge. A pin watches for both edges when its rising and falling select bits are both set. A condition that occurs sets that pin's bit in one shared raw event word. The bit stays set until software acknowledges it.

Two interrupt outputs read the same raw event word, and each output has its own enable mask. Software changes a mask only through a set port and a clear port, where each 1 bit in the written word sets or clears that enable bit. An interrupt output is high while any pin has both its raw event bit and that output's enable bit set. Access is through a plain 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the current register state.

Top module: `gpio_irq_events`

## Requirements
- R1: After a clock edge with `rst_n` low, every select register, the raw event word and both enable masks read 0, and both `irq_o` bits are 0.
- R2: The select registers can be written and read back at these addresses: low level at 0x140, high level at 0x144, rising edge at 0x148, falling edge at 0x14C. Bit p of each register applies to pin p.
- R3: A rising edge (with the rising select bit set) or a falling edge (with the falling select bit set) sets the raw bit, and the bit stays set after the pin returns to its old level. Setting both select bits for a pin catches each edge in either direction.
- R4: A pin with a level select bit set, and whose level condition holds, sets its raw bit. An acknowledge has no effect while the condition still holds. An acknowledge clears the bit once the condition is gone.
- R5: The raw event word reads the same at 0x024 and at 0x028. Writing a 1 bit to 0x02C or to 0x030 clears that shared raw bit. Writing a 0 bit leaves it unchanged.
- R6: Writing a 1 bit to 0x034 (output 0) or 0x038 (output 1) sets that enable bit. Writing a 1 bit to 0x03C (output 0) or 0x040 (output 1) clears it. A 0 bit has no effect. Both the set address and the clear address of an output read back that output's current mask.
- R7: Address 0x02C reads the raw word ANDed with the output 0 mask. Address 0x030 reads the raw word ANDed with the output 1 mask.
- R8: `irq_o[k]` is 1 exactly when the raw word ANDed with mask k is nonzero. It follows the register state with no extra delay.
- R9: If a new edge event arrives on a pin in the same cycle that its raw bit is acknowledged, the bit stays set.
- R10: Pin p maps to raw bit p. A pin change driven before clock edge n shows in the raw word after edge n+2, not after edge n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 32 | Asynchronous pin levels |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 2 | Interrupt outputs 0 and 1 |

## Verification
Two functions can fall in the same cycle: a software acknowledge of a raw bit, and a fresh edge event on that same pin. The bench provokes this by counting the two synchroniser edges after a pin rises. It then places the acknowledge write exactly on the edge where the new event is captured, and expects the bit to read back set. A second acknowledge, made when no edge is present, must clear the bit. The bench also checks that a level condition which still holds wins over an acknowledge in every cycle.

// File: rtl/gpio_evt_pkg.sv
// Shared register map and helpers for the GPIO interrupt event unit.
package gpio_evt_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int REG_AW    = 12;
    localparam int NUM_LINES = 2;
    localparam int NUM_SEL   = 4;
    localparam int LINE_STEP = 4;

    typedef logic [REG_AW-1:0] reg_addr_t;

    // Select-register indices; their order follows the address order.
    localparam int SEL_LOW  = 0;
    localparam int SEL_HIGH = 1;
    localparam int SEL_RISE = 2;
    localparam int SEL_FALL = 3;

    localparam reg_addr_t A_RAW0     = 12'h024;
    localparam reg_addr_t A_RAW1     = 12'h028;
    localparam reg_addr_t A_STAT0    = 12'h02C;
    localparam reg_addr_t A_ENSET0   = 12'h034;
    localparam reg_addr_t A_ENCLR0   = 12'h03C;
    localparam reg_addr_t A_SEL_BASE = 12'h140;

    // Address of item k in a block of registers spaced one word apart.
    function automatic reg_addr_t word_addr(reg_addr_t base, int k);
        return base + reg_addr_t'(LINE_STEP * k);
    endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
// Two-flop synchroniser for the pin bank.
// Assumes: pin_in is asynchronous; one output bit per input bit.
module gpio_evt_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    assign pin_sync = sync_q;

    // Counts edges since reset so the latency check never reaches into the reset cycles.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (pin_sync == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_evt_detect.sv
// Finds events on each pin and holds them in the raw event word.
// Assumes: pin_sync is already in the clock domain; ack is a one-cycle clear mask.
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] sel_low,
    input  logic [W-1:0] sel_high,
    input  logic [W-1:0] sel_rise,
    input  logic [W-1:0] sel_fall,
    input  logic [W-1:0] ack,
    output logic [W-1:0] raw
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] raw_q;

    // Holds the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    // Per-pin event: any selected condition that holds this cycle.
    for (genvar p = 0; p < W; p++) begin : g_pin
        assign hit[p] = (sel_low[p]  & ~pin_sync[p])
                      | (sel_high[p] &  pin_sync[p])
                      | (sel_rise[p] &  pin_sync[p] & ~prev_q[p])
                      | (sel_fall[p] & ~pin_sync[p] &  prev_q[p]);
    end

    // Raw word: an acknowledge clears a bit, and a new event sets it again in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~ack) | hit;
    end

    assign raw = raw_q;

    p_hold_unacked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & ~ack) != '0) |=> ((raw_q & $past(raw_q & ~ack)) == $past(raw_q & ~ack)));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~hit) != '0) |=> ((raw_q & $past(ack & ~hit)) == '0));

    p_new_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & sel_rise & pin_sync & ~prev_q) != '0)
        |=> ((raw_q & $past(ack & sel_rise & pin_sync & ~prev_q)) != '0));

    p_level_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((sel_high & pin_sync) | (sel_low & ~pin_sync)) != '0)
        |=> ((raw_q & $past((sel_high & pin_sync) | (sel_low & ~pin_sync)))
             == $past((sel_high & pin_sync) | (sel_low & ~pin_sync))));
endmodule

// File: rtl/gpio_evt_ctrl.sv
// Register port: select registers, enable masks per output, acknowledge and read mux.
// Assumes: one register access per cycle; reads are combinational.
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int W  = 32,
    parameter int NL = NUM_LINES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  reg_addr_t              reg_addr,
    input  logic                   reg_we,
    input  logic [W-1:0]           reg_wdata,
    input  logic [W-1:0]           raw,
    output logic [NUM_SEL-1:0][W-1:0] sel,
    output logic [W-1:0]           ack,
    output logic [NL-1:0][W-1:0]   line_en,
    output logic [W-1:0]           rd_data
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NUM_SEL-1:0][W-1:0] sel_q;
    logic [NL-1:0][W-1:0]      en_q;

    // Select registers, one word apart from the base address.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        localparam reg_addr_t SEL_A = word_addr(A_SEL_BASE, i);

        // Plain read/write storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[i] <= '0;
            else if (reg_we && reg_addr == SEL_A)
                sel_q[i] <= reg_wdata;
        end
    end

    // Enable masks per output, changed only through the set and clear ports.
    for (genvar k = 0; k < NL; k++) begin : g_line
        localparam reg_addr_t SET_A = word_addr(A_ENSET0, k);
        localparam reg_addr_t CLR_A = word_addr(A_ENCLR0, k);

        // 1 bits set or clear the mask; 0 bits leave it unchanged.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[k] <= '0;
            else if (reg_we && reg_addr == SET_A)
                en_q[k] <= en_q[k] | reg_wdata;
            else if (reg_we && reg_addr == CLR_A)
                en_q[k] <= en_q[k] & ~reg_wdata;
        end

        p_en_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == SET_A) |=> ((en_q[k] & $past(reg_wdata)) == $past(reg_wdata)));

        p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == CLR_A) |=> ((en_q[k] & $past(reg_wdata)) == '0));

        p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_we |=> $stable(en_q[k]));
    end

    // Acknowledge mask: a write to either output's status address clears shared raw bits.
    always_comb begin
        ack = '0;
        for (int k = 0; k < NL; k++)
            if (reg_we && reg_addr == word_addr(A_STAT0, k))
                ack = ack | reg_wdata;
    end

    // Read mux over every readable address.
    always_comb begin
        rd_data = '0;
        if (reg_addr == A_RAW0 || reg_addr == A_RAW1)
            rd_data = raw;
        for (int i = 0; i < NUM_SEL; i++)
            if (reg_addr == word_addr(A_SEL_BASE, i))
                rd_data = sel_q[i];
        for (int k = 0; k < NL; k++) begin
            if (reg_addr == word_addr(A_STAT0, k))
                rd_data = raw & en_q[k];
            if (reg_addr == word_addr(A_ENSET0, k) || reg_addr == word_addr(A_ENCLR0, k))
                rd_data = en_q[k];
        end
    end

    assign sel     = sel_q;
    assign line_en = en_q;

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(sel_q));
endmodule

// File: rtl/gpio_irq_events.sv
// Top of the GPIO interrupt event unit: synchroniser, event detection, register port and output ORs.
// Assumes: single clock domain, synchronous active-low reset.
module gpio_irq_events
    import gpio_evt_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pin_in,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [NPINS-1:0]     reg_wdata,
    output logic [NPINS-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NPINS-1:0]                pin_sync;
    logic [NPINS-1:0]                raw;
    logic [NPINS-1:0]                ack;
    logic [NUM_SEL-1:0][NPINS-1:0]   sel;
    logic [NUM_LINES-1:0][NPINS-1:0] line_en;

    gpio_evt_sync #(.W(NPINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_evt_detect #(.W(NPINS)) i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .sel_low  (sel[SEL_LOW]),
        .sel_high (sel[SEL_HIGH]),
        .sel_rise (sel[SEL_RISE]),
        .sel_fall (sel[SEL_FALL]),
        .ack      (ack),
        .raw      (raw)
    );

    gpio_evt_ctrl #(.W(NPINS), .NL(NUM_LINES)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .raw       (raw),
        .sel       (sel),
        .ack       (ack),
        .line_en   (line_en),
        .rd_data   (reg_rdata)
    );

    // Each output is the OR of raw events that its mask lets through.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_irq
        assign irq_o[k] = |(raw & line_en[k]);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

    p_stat_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STAT0) |-> ((reg_rdata & ~raw) == '0));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> (raw != '0));
endmodule

// File: tb/test_gpio_irq_events.sv
// Scoreboard bench: the driver queues expected reads, and a monitor pops and compares them.
module test_gpio_irq_events;
    timeunit 1ns;
    timeprecision 100ps;
    import gpio_evt_pkg::*;

    localparam int W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [W-1:0]    pins = '0;
    reg_addr_t       addr = '0;
    logic            we = 1'b0;
    logic [W-1:0]    wdata = '0;
    logic [W-1:0]    rdata;
    logic [1:0]      irq;

    always #2.5 clk = ~clk;

    gpio_irq_events i_gpio_irq_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq)
    );

    typedef struct {
        reg_addr_t    a;
        logic [W-1:0] d;
        logic [1:0]   q;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    task automatic chk(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per falling edge and compares read data and outputs.
    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                addr = e.a;
                #1;
                chk(rdata === e.d, e.tag, "rd_data", rdata, e.d);
                chk(irq === e.q, e.tag, "irq", {30'd0, irq}, {30'd0, e.q});
            end
        end
    end

    task automatic expect_rd(reg_addr_t a, logic [W-1:0] d, logic [1:0] q, string tag);
        exp_t e;
        e.a = a; e.d = d; e.q = q; e.tag = tag;
        sb.push_back(e);
        while (sb.size() != 0) @(negedge clk);
        #2;
    endtask

    task automatic wr(reg_addr_t a, logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic set_pins(logic [W-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        expect_rd(12'h024, 32'h0, 2'b00, "R1 raw");
        expect_rd(12'h034, 32'h0, 2'b00, "R1 en0");
        expect_rd(12'h040, 32'h0, 2'b00, "R1 en1");
        expect_rd(12'h148, 32'h0, 2'b00, "R1 sel_rise");

        // R2 select registers
        wr(12'h148, 32'h9);
        wr(12'h14C, 32'hA);
        wr(12'h144, 32'h4);
        repeat (3) @(posedge clk);
        expect_rd(12'h148, 32'h9, 2'b00, "R2 rise");
        expect_rd(12'h14C, 32'hA, 2'b00, "R2 fall");
        expect_rd(12'h144, 32'h4, 2'b00, "R2 high");
        expect_rd(12'h140, 32'h0, 2'b00, "R2 low");
        expect_rd(12'h024, 32'h0, 2'b00, "R2 raw idle");

        // R10 latency through the synchroniser
        @(negedge clk) pins = 32'h1;
        @(posedge clk);
        @(posedge clk);
        expect_rd(12'h024, 32'h0, 2'b00, "R10 not yet");
        @(posedge clk);
        expect_rd(12'h024, 32'h1, 2'b00, "R10 third edge");

        // R6 / R7 / R8 enable output 0
        expect_rd(12'h02C, 32'h0, 2'b00, "R7 masked before enable");
        wr(12'h034, 32'h1);
        expect_rd(12'h034, 32'h1, 2'b01, "R6 set0 readback");
        expect_rd(12'h03C, 32'h1, 2'b01, "R6 clr0 readback");
        expect_rd(12'h038, 32'h0, 2'b01, "R6 en1 untouched");
        expect_rd(12'h02C, 32'h1, 2'b01, "R7 stat0");
        expect_rd(12'h030, 32'h0, 2'b01, "R7 stat1");
        wr(12'h038, 32'h0);
        expect_rd(12'h040, 32'h0, 2'b01, "R6 zero set no effect");

        // R3 edges and high level
        set_pins(32'hF);
        expect_rd(12'h024, 32'hD, 2'b01, "R3 rise and high");
        set_pins(32'h4);
        expect_rd(12'h024, 32'hF, 2'b01, "R3 fall");
        wr(12'h030, 32'h8);
        expect_rd(12'h028, 32'h7, 2'b01, "R5 ack via line1 shared");
        expect_rd(12'h024, 32'h7, 2'b01, "R5 raw alias");
        set_pins(32'hC);
        expect_rd(12'h024, 32'hF, 2'b01, "R3 both-edge rise");
        wr(12'h02C, 32'h8);
        expect_rd(12'h024, 32'h7, 2'b01, "R5 ack via line0");
        set_pins(32'h4);
        expect_rd(12'h024, 32'hF, 2'b01, "R3 both-edge fall");

        // R4 level still true
        wr(12'h02C, 32'h4);
        expect_rd(12'h024, 32'hF, 2'b01, "R4 level re-raises");
        set_pins(32'h0);
        expect_rd(12'h024, 32'hF, 2'b01, "R3 edge stays latched");
        wr(12'h02C, 32'h4);
        expect_rd(12'h024, 32'hB, 2'b01, "R4 ack after level gone");
        wr(12'h02C, 32'h0);
        expect_rd(12'h024, 32'hB, 2'b01, "R5 zero ack no effect");

        // R6 / R8 output 1
        wr(12'h038, 32'h2);
        expect_rd(12'h040, 32'h2, 2'b11, "R8 both lines");
        wr(12'h03C, 32'h1);
        expect_rd(12'h034, 32'h0, 2'b10, "R6 clear en0");
        wr(12'h040, 32'h0);
        expect_rd(12'h038, 32'h2, 2'b10, "R6 zero clear no effect");
        expect_rd(12'h030, 32'h2, 2'b10, "R7 stat1");

        // R9 new edge in the acknowledge cycle
        wr(12'h02C, 32'hFFFF_FFFF);
        expect_rd(12'h024, 32'h0, 2'b00, "R5 full ack");
        @(negedge clk) pins = 32'h1;
        @(posedge clk);
        @(posedge clk);
        wr(12'h02C, 32'h1);
        expect_rd(12'h024, 32'h1, 2'b00, "R9 edge wins over ack");
        wr(12'h02C, 32'h1);
        expect_rd(12'h024, 32'h0, 2'b00, "R9 later ack clears");

        // R4 low level on pin 31
        wr(12'h140, 32'h8000_0000);
        repeat (3) @(posedge clk);
        expect_rd(12'h024, 32'h8000_0000, 2'b00, "R4 low level");
        wr(12'h02C, 32'h8000_0000);
        expect_rd(12'h024, 32'h8000_0000, 2'b00, "R4 low level held");
        set_pins(32'h8000_0001);
        wr(12'h02C, 32'h8000_0000);
        expect_rd(12'h024, 32'h0, 2'b00, "R4 low level released");

        done = 1'b1;
        finish_run();
    end
endmodule